// File: doc/BRIEF.md
# Saturating Pack Narrowing Unit

This unit takes two operands, called the destination operand and the source operand. It halves the width of every element in each operand. Any value that does not fit the narrower type is clamped to the nearest value the narrow type can hold. The two narrowed vectors are then joined into one result. The destination's narrowed elements always form the low part of the result and the source's narrowed elements form the part above it. It is used in a vector datapath to reduce wide intermediate values, such as filter sums or products, to a compact storage type without wrap-around.

A 2-bit mode selects one of three narrowings:
- signed 16-bit to signed 8-bit;
- signed 16-bit to unsigned 8-bit;
- signed 32-bit to signed 16-bit.

The fourth mode code is reserved. A width select chooses between two operand sizes. With full width the whole operand is used. With half width only the low half of each operand is used, and the upper half of the result is zero.

The result is registered. It appears one clock cycle after an accepted input, together with a valid flag. A per-element mask marks which output elements were clamped.

Top module: `pack_narrow_unit`

## Requirements
- R1: Mode code 0 reads each 16-bit element as signed and produces an 8-bit signed value clamped to -128..127 (0x80..0x7F).
- R2: Mode code 1 reads each 16-bit element as signed and produces an 8-bit unsigned value clamped to 0..255. A negative input gives 0x00 and an input above 255 gives 0xFF.
- R3: Mode code 2 reads each 32-bit element as signed and produces a 16-bit value clamped to -32768..32767 (0x8000..0x7FFF).
- R4: Element i of the narrowed destination operand occupies output element i. Element i of the narrowed source operand occupies output element i+N, where N is the number of elements per operand.
- R5: With `full_width` = 0, only the low DATA_W/2 bits of each operand are read and result bits DATA_W-1..DATA_W/2 are zero. With `full_width` = 1, the whole operands are read.
- R6: Mode code 3 is reserved. An accepted input with this code gives an all-zero result and an all-zero mask.
- R7: Bit i of `sat_mask` is 1 exactly when output element i was clamped. Mask bits at or above 2N are 0.
- R8: `result` and `sat_mask` update, and `out_valid` is 1, in the cycle after `in_valid` was 1. `out_valid` is 0 in the cycle after `in_valid` was 0.
- R9: While `in_valid` is 0, `result` and `sat_mask` keep their last values regardless of the operand, mode and width inputs.
- R10: A synchronous active-high `rst` clears `out_valid`, `result` and `sat_mask` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| dst_opnd | input | DATA_W | Operand whose narrowed elements fill the low part of the result |
| src_opnd | input | DATA_W | Operand whose narrowed elements fill the part above them |
| mode | input | 2 | Narrowing mode: 0 signed 16 to signed 8, 1 signed 16 to unsigned 8, 2 signed 32 to signed 16, 3 reserved |
| full_width | input | 1 | 1 uses whole operands; 0 uses their low halves |
| out_valid | output | 1 | Result registers were loaded in the previous cycle |
| result | output | DATA_W | Registered packed result |
| sat_mask | output | DATA_W/8 | Registered per-output-element clamp flags |

## Verification
Fixed operands containing 0x0000, 0x5A5A, 0xA5A5, 0xFFFF, 0x8000, 0x00FF, 0x007F and 0x003F are packed in all three modes. The same pair gives three different answers, which separates signed clamping from unsigned clamping and word narrowing from doubleword narrowing. An ascending-element pattern exposes any swap between the destination and source halves or any reordering of lanes. Random operands built from words on the clamp boundaries (0x007F/0x0080, 0xFF80/0xFF7F, 0x00FF/0x0100, 0x7FFF/0x8000) are mixed with idle cycles, reserved codes and both widths. This exposes off-by-one clamp limits, wrong sign handling, stray upper result bits, mask misplacement and results that change without a valid input.

// File: rtl/pack_pkg.sv
package pack_pkg;

    typedef enum logic [1:0] {
        PK_S16_S8  = 2'd0,
        PK_S16_U8  = 2'd1,
        PK_S32_S16 = 2'd2,
        PK_RSVD    = 2'd3
    } pack_mode_e;

endpackage

// File: rtl/narrow_lane.sv
// Clamps one signed element of IN_W bits into IN_W/2 bits.
module narrow_lane #(
    parameter int IN_W = 16
) (
    input  logic [IN_W-1:0]   val,
    input  logic              to_unsigned,
    output logic [IN_W/2-1:0] nar,
    output logic              clipped
);
    localparam int OUT_W = IN_W / 2;

    logic neg;
    logic fits_signed;
    logic over_unsigned;

    assign neg           = val[IN_W-1];
    // top bits down to the narrow sign bit must all agree
    assign fits_signed   = (&val[IN_W-1:OUT_W-1]) | ~(|val[IN_W-1:OUT_W-1]);
    assign over_unsigned = |val[IN_W-2:OUT_W];

    always_comb begin
        nar     = val[OUT_W-1:0];
        clipped = 1'b0;
        if (to_unsigned) begin
            if (neg) begin
                nar     = '0;
                clipped = 1'b1;
            end else if (over_unsigned) begin
                nar     = '1;
                clipped = 1'b1;
            end
        end else if (!fits_signed) begin
            nar     = neg ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
            clipped = 1'b1;
        end
    end

endmodule

// File: rtl/pack_half.sv
// Narrows every element of one operand for the selected mode.
module pack_half
    import pack_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0]    opnd,
    input  pack_mode_e           mode,
    output logic [DATA_W/2-1:0]  narrowed,
    output logic [DATA_W/16-1:0] flags
);
    localparam int HALF_W = DATA_W / 2;
    localparam int LW     = DATA_W / 16;
    localparam int LD     = DATA_W / 32;

    logic [HALF_W-1:0] w_nar;
    logic [HALF_W-1:0] d_nar;
    logic [LW-1:0]     w_flg;
    logic [LD-1:0]     d_flg;
    logic              unsigned_tgt;

    assign unsigned_tgt = (mode == PK_S16_U8);

    for (genvar g = 0; g < LW; g++) begin : g_word
        narrow_lane #(.IN_W(16)) u_lane (
            .val        (opnd[g*16 +: 16]),
            .to_unsigned(unsigned_tgt),
            .nar        (w_nar[g*8 +: 8]),
            .clipped    (w_flg[g])
        );
    end

    for (genvar g = 0; g < LD; g++) begin : g_dword
        narrow_lane #(.IN_W(32)) u_lane (
            .val        (opnd[g*32 +: 32]),
            .to_unsigned(1'b0),
            .nar        (d_nar[g*16 +: 16]),
            .clipped    (d_flg[g])
        );
    end

    assign narrowed = (mode == PK_S32_S16) ? d_nar : w_nar;
    assign flags    = (mode == PK_S32_S16) ? LW'(d_flg) : w_flg;

endmodule

// File: rtl/pack_narrow_unit.sv
module pack_narrow_unit
    import pack_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   dst_opnd,
    input  logic [DATA_W-1:0]   src_opnd,
    input  logic [1:0]          mode,
    input  logic                full_width,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic [DATA_W/8-1:0] sat_mask
);
    localparam int HALF_W = DATA_W / 2;
    localparam int QTR_W  = DATA_W / 4;
    localparam int LW     = DATA_W / 16;
    localparam int LD     = DATA_W / 32;
    localparam int MASK_W = DATA_W / 8;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [MASK_W-1:0] mask;
    } pk_state_t;

    pk_state_t  st_d, st_q;
    pack_mode_e mode_e;

    logic [HALF_W-1:0] dst_n, src_n;
    logic [LW-1:0]     dst_f, src_f;

    assign mode_e = pack_mode_e'(mode);

    pack_half #(.DATA_W(DATA_W)) u_dst (
        .opnd(dst_opnd), .mode(mode_e), .narrowed(dst_n), .flags(dst_f)
    );
    pack_half #(.DATA_W(DATA_W)) u_src (
        .opnd(src_opnd), .mode(mode_e), .narrowed(src_n), .flags(src_f)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            case (mode_e)
                PK_RSVD: begin
                    st_d.res  = '0;
                    st_d.mask = '0;
                end
                PK_S32_S16: begin
                    if (full_width) begin
                        st_d.res  = {src_n, dst_n};
                        st_d.mask = MASK_W'({src_f[LD-1:0], dst_f[LD-1:0]});
                    end else begin
                        st_d.res  = DATA_W'({src_n[QTR_W-1:0], dst_n[QTR_W-1:0]});
                        st_d.mask = MASK_W'({src_f[LD/2-1:0], dst_f[LD/2-1:0]});
                    end
                end
                default: begin
                    if (full_width) begin
                        st_d.res  = {src_n, dst_n};
                        st_d.mask = {src_f, dst_f};
                    end else begin
                        st_d.res  = DATA_W'({src_n[QTR_W-1:0], dst_n[QTR_W-1:0]});
                        st_d.mask = MASK_W'({src_f[LW/2-1:0], dst_f[LW/2-1:0]});
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign sat_mask  = st_q.mask;

    // R8: a valid output follows every accepted input, and only those
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9: idle cycles leave the registered output untouched
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(sat_mask)));
    // R5: half-width packing never writes the upper result half
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !full_width) |=> (result[DATA_W-1:HALF_W] == '0));
    // R6: reserved code yields nothing
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd3) |=> (result == '0 && sat_mask == '0));
    // R7: mask never flags elements beyond the count in half-width dword packing
    a_r7_mask_range: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd2 && !full_width) |=> (sat_mask[MASK_W-1:LD] == '0));

endmodule

// File: tb/tb_pack_narrow_unit.sv
`timescale 1ns/1ps
module tb_pack_narrow_unit;

    localparam int DATA_W = 128;
    localparam int MASK_W = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] dst_opnd = '0;
    logic [DATA_W-1:0] src_opnd = '0;
    logic [1:0]        mode = 2'd0;
    logic              full_width = 1'b0;
    logic              out_valid;
    logic [DATA_W-1:0] result;
    logic [MASK_W-1:0] sat_mask;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] exp_res  = '0;
    logic [MASK_W-1:0] exp_mask = '0;
    logic              exp_vld  = 1'b0;

    always #10 clk = ~clk;

    pack_narrow_unit #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .dst_opnd(dst_opnd), .src_opnd(src_opnd),
        .mode(mode), .full_width(full_width),
        .out_valid(out_valid), .result(result), .sat_mask(sat_mask)
    );

    task automatic check(input string tag, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference: clamp each element with integer arithmetic.
    task automatic ref_calc(input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] s,
                            input logic [1:0] m, input bit w,
                            output logic [DATA_W-1:0] r, output logic [MASK_W-1:0] mk);
        int    ne;
        longint lo, hi, v, c;
        logic [DATA_W-1:0] op;
        r  = '0;
        mk = '0;
        if (m == 2'd3) return;
        ne = (m == 2'd2) ? (w ? DATA_W/32 : DATA_W/64) : (w ? DATA_W/16 : DATA_W/32);
        lo = (m == 2'd1) ? 0 : ((m == 2'd2) ? -32768 : -128);
        hi = (m == 2'd1) ? 255 : ((m == 2'd2) ? 32767 : 127);
        for (int k = 0; k < 2; k++) begin
            op = (k == 0) ? d : s;
            for (int e = 0; e < ne; e++) begin
                int idx;
                idx = k * ne + e;
                if (m == 2'd2) v = longint'($signed(op[e*32 +: 32]));
                else           v = longint'($signed(op[e*16 +: 16]));
                if (v < lo)      begin c = lo; mk[idx] = 1'b1; end
                else if (v > hi) begin c = hi; mk[idx] = 1'b1; end
                else             c = v;
                if (m == 2'd2) r[idx*16 +: 16] = c[15:0];
                else           r[idx*8 +: 8]   = c[7:0];
            end
        end
    endtask

    task automatic step(input bit v, input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] s,
                        input logic [1:0] m, input bit w, input string tag);
        @(negedge clk);
        in_valid = v; dst_opnd = d; src_opnd = s; mode = m; full_width = w;
        if (v) ref_calc(d, s, m, w, exp_res, exp_mask);
        exp_vld = v;
        @(posedge clk);
        #5;
        check(tag, result, exp_res);
        check({tag, "/R7 mask"}, DATA_W'(sat_mask), DATA_W'(exp_mask));
        check({tag, "/R8 valid"}, DATA_W'(out_valid), DATA_W'(exp_vld));
    endtask

    function automatic logic [15:0] pick16();
        case ($urandom % 12)
            0: return 16'h007F;  1: return 16'h0080;
            2: return 16'hFF80;  3: return 16'hFF7F;
            4: return 16'h00FF;  5: return 16'h0100;
            6: return 16'h8000;  7: return 16'h7FFF;
            8: return 16'hFFFF;  9: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pick_opnd();
        logic [DATA_W-1:0] o;
        for (int i = 0; i < DATA_W/16; i++) o[i*16 +: 16] = pick16();
        return o;
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] da, sa;
        da = {64'h1111_2222_3333_4444, 64'hFFFFA5A55A5A0000};
        sa = {64'h5555_6666_7777_8888, 64'h8000003F007F00FF};

        repeat (3) @(posedge clk);
        #5;
        // R10: reset state
        check("R10 reset result", result, '0);
        check("R10 reset valid", DATA_W'(out_valid), '0);
        check("R10 reset mask", DATA_W'(sat_mask), '0);
        @(negedge clk);
        rst = 1'b0;

        // Fixed example pairs in half-width mode (upper operand bits are ignored).
        step(1'b1, da, sa, 2'd0, 1'b0, "R1");
        check("R1/R5 example signed byte", result, DATA_W'(64'h803F7F7FFF807F00));
        step(1'b1, da, sa, 2'd1, 1'b0, "R2");
        check("R2/R5 example unsigned byte", result, DATA_W'(64'h003F7FFF0000FF00));
        step(1'b1, da, sa, 2'd2, 1'b0, "R3");
        check("R3/R5 example signed word", result, DATA_W'(64'h80007FFFA5A57FFF));

        // R4: element ordering in full width
        step(1'b1, 128'h0008_0007_0006_0005_0004_0003_0002_0001,
                   128'h0018_0017_0016_0015_0014_0013_0012_0011, 2'd0, 1'b1, "R4");
        check("R4 placement", result, 128'h1817161514131211_0807060504030201);

        // R6: reserved code clears result
        step(1'b1, da, sa, 2'd3, 1'b1, "R6");
        check("R6 reserved", result, '0);

        // R9: idle cycles with changing inputs
        step(1'b1, da, sa, 2'd1, 1'b1, "R2");
        step(1'b0, pick_opnd(), pick_opnd(), 2'd2, 1'b0, "R9");
        step(1'b0, pick_opnd(), pick_opnd(), 2'd0, 1'b1, "R9");

        // Mixed traffic compared with the model on every clock.
        for (int i = 0; i < 400; i++) begin
            bit v;
            logic [1:0] m;
            string tg;
            v = ($urandom % 4) != 0;
            m = 2'($urandom);
            tg = !v ? "R9" : (m == 2'd0) ? "R1" : (m == 2'd1) ? "R2" :
                 (m == 2'd2) ? "R3" : "R6";
            step(v, pick_opnd(), pick_opnd(), m, 1'($urandom), tg);
            if (v && !full_width)
                check("R5 upper zero", DATA_W'(result[DATA_W-1:DATA_W/2]), '0);
        end

        // R10: reset while a valid input is applied
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; mode = 2'd0; dst_opnd = da; src_opnd = sa;
        @(posedge clk);
        #5;
        check("R10 mid reset result", result, '0);
        check("R10 mid reset valid", DATA_W'(out_valid), '0);
        check("R10 mid reset mask", DATA_W'(sat_mask), '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule